// File: doc/BRIEF.md
# Circular Event Queue Producer

This block appends 32-bit event words to a circular queue that lives in system memory. The caller hands it the queue descriptor with each request: a byte base address, a size code, the slot index to fill next, the current generation bit and a generation-flipped flag. The block builds the entry with the generation bit on top, issues a single memory write to the slot, and then returns the descriptor fields that the caller must store back.

The queue holds 2^(size_code+10) slots of four bytes each. Each time the index wraps to slot zero, the producer inverts its generation bit. A consumer can therefore tell a fresh entry from a stale one by comparing bit 31 with the generation it expects, and no shared read pointer is needed. Only one request is in flight at a time. A failed write leaves the queue position untouched. A size code outside the supported range is refused before any memory traffic.

Top module: `evq_writer`

## Requirements
- R1: The stored entry has the descriptor's generation bit in bit 31 and bits 30:0 of the event data below it.
- R2: Entries are stored most-significant byte first: `mem_wdata[7:0]` (lowest address) carries entry bits 31:24 and `mem_wdata[31:24]` carries entry bits 7:0.
- R3: `mem_addr` equals the base plus four times the index, with index bits at or above size_code+10 taken as zero, modulo 2^32.
- R4: After a successful write (`mem_ack` with `mem_err` low), `upd_valid` is high for exactly one cycle, starting the cycle after the acknowledge, with `upd_ok`=1 and `upd_idx` = (index+1) mod 2^(size_code+10).
- R5: When the advanced index is zero, `upd_gen` is the inverted generation and `upd_flip` equals the new `upd_gen`; otherwise both are returned unchanged.
- R6: If the write returns `mem_err`=1, the update has `upd_ok`=0 and returns the original index, generation and flag.
- R7: A size code above 5 gives a one-cycle `cfg_err` pulse in the cycle after acceptance, with no `mem_req` and no `upd_valid`.
- R8: `req_ready` is high only when idle. `busy` and `mem_req` rise in the cycle after a valid request is accepted and stay high until the acknowledge. While `mem_req` waits, `mem_addr` and `mem_wdata` hold steady.
- R9: Out of reset `mem_req`, `busy`, `upd_valid` and `cfg_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Enqueue request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_data | input | 32 | Event data (bit 31 discarded) |
| desc_base | input | 32 | Queue byte base address |
| desc_size | input | 3 | Size code, slots = 2^(code+10) |
| desc_idx | input | 15 | Slot to fill |
| desc_gen | input | 1 | Current generation bit |
| desc_flip | input | 1 | Generation-flipped flag |
| busy | output | 1 | Write in flight |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data, byte lane 0 at lowest address |
| mem_ack | input | 1 | Write acknowledge, completes the request |
| mem_err | input | 1 | Error response, valid with mem_ack |
| upd_valid | output | 1 | Updated descriptor valid pulse |
| upd_ok | output | 1 | Write succeeded |
| upd_idx | output | 15 | Index to write back |
| upd_gen | output | 1 | Generation to write back |
| upd_flip | output | 1 | Flipped flag to write back |
| cfg_err | output | 1 | Rejected size code pulse |

## Verification
A corrupted captured index or generation shows at the ports in the very next cycle as a wrong `mem_addr` or a wrong bit 31 in `mem_wdata`. A fault in the advance or wrap logic shows one cycle after the acknowledge in `upd_idx`, `upd_gen` or `upd_flip`. The wrap case is driven at the last slot of the smallest and largest queues. Error responses and refused size codes are also driven, so that an update wrongly applied, or traffic wrongly issued, is seen in the same request.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned EVQ_SZ_BIAS = 10;
  typedef enum logic [0:0] { ST_IDLE = 1'b0, ST_WRITE = 1'b1 } evq_state_e;
endpackage

// File: rtl/evq_entry_fmt.sv
module evq_entry_fmt #(
  parameter int unsigned DW = 32
) (
  input  logic          gen,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] bus_word
);
  localparam int unsigned NB = DW / 8;
  logic [DW-1:0] entry;

  assign entry = {gen, data[DW-2:0]};

  // first byte in memory is the entry's top byte
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign bus_word[8*b +: 8] = entry[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/evq_index_step.sv
module evq_index_step
  import evq_pkg::*;
#(
  parameter int unsigned IDXW = 15,
  parameter int unsigned SZW  = 3
) (
  input  logic [SZW-1:0]  size,
  input  logic [IDXW-1:0] idx,
  input  logic            gen,
  input  logic            flip,
  output logic [IDXW-1:0] idx_masked,
  output logic [IDXW-1:0] idx_next,
  output logic            gen_next,
  output logic            flip_next
);
  logic [IDXW-1:0] mask;
  logic [IDXW:0]   sum;
  logic            wrap;

  for (genvar i = 0; i < IDXW; i++) begin : g_mask
    assign mask[i] = (32'(size) + 32'(EVQ_SZ_BIAS)) > 32'(i);
  end

  assign idx_masked = idx & mask;
  assign sum        = {1'b0, idx_masked} + {{IDXW{1'b0}}, 1'b1};
  assign idx_next   = sum[IDXW-1:0] & mask;
  assign wrap       = (idx_next == '0);
  assign gen_next   = wrap ? ~gen : gen;
  assign flip_next  = wrap ? ~gen : flip;
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned IDXW     = 15,
  parameter int unsigned SZW      = 3,
  parameter int unsigned MAX_SIZE = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_data,
  input  logic [AW-1:0]   desc_base,
  input  logic [SZW-1:0]  desc_size,
  input  logic [IDXW-1:0] desc_idx,
  input  logic            desc_gen,
  input  logic            desc_flip,
  output logic            busy,
  output logic            mem_req,
  input  logic            mem_ack,
  input  logic            mem_err,
  output logic [DW-1:0]   cap_data,
  output logic [AW-1:0]   cap_base,
  output logic [SZW-1:0]  cap_size,
  output logic [IDXW-1:0] cap_idx,
  output logic            cap_gen,
  output logic            cap_flip,
  input  logic [IDXW-1:0] step_idx,
  input  logic            step_gen,
  input  logic            step_flip,
  output logic            upd_valid,
  output logic            upd_ok,
  output logic [IDXW-1:0] upd_idx,
  output logic            upd_gen,
  output logic            upd_flip,
  output logic            cfg_err
);
  evq_state_e state_q, state_d;
  logic cap_en, upd_en, err_d, size_ok;
  logic upd_ok_d, upd_gen_d, upd_flip_d;
  logic [IDXW-1:0] upd_idx_d;

  assign size_ok   = 32'(desc_size) <= 32'(MAX_SIZE);
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_WRITE);
  assign mem_req   = (state_q == ST_WRITE);

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    upd_en  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (size_ok) begin
            cap_en  = 1'b1;
            state_d = ST_WRITE;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          upd_en  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    upd_ok_d   = ~mem_err;
    upd_idx_d  = mem_err ? cap_idx  : step_idx;
    upd_gen_d  = mem_err ? cap_gen  : step_gen;
    upd_flip_d = mem_err ? cap_flip : step_flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      upd_valid <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      upd_valid <= upd_en;
      cfg_err   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      cap_base <= '0;
      cap_size <= '0;
      cap_idx  <= '0;
      cap_gen  <= 1'b0;
      cap_flip <= 1'b0;
    end else if (cap_en) begin
      cap_data <= req_data;
      cap_base <= desc_base;
      cap_size <= desc_size;
      cap_idx  <= desc_idx;
      cap_gen  <= desc_gen;
      cap_flip <= desc_flip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_ok   <= 1'b0;
      upd_idx  <= '0;
      upd_gen  <= 1'b0;
      upd_flip <= 1'b0;
    end else if (upd_en) begin
      upd_ok   <= upd_ok_d;
      upd_idx  <= upd_idx_d;
      upd_gen  <= upd_gen_d;
      upd_flip <= upd_flip_d;
    end
  end

  p_busy_from_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!mem_req && !upd_valid));
  p_err_keeps_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ok) |-> (upd_idx == cap_idx && upd_gen == cap_gen));
endmodule

// File: rtl/evq_writer.sv
module evq_writer
  import evq_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned SZW      = 3,
  parameter int unsigned MAX_SIZE = 5,
  parameter int unsigned IDXW     = MAX_SIZE + EVQ_SZ_BIAS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_data,
  input  logic [AW-1:0]   desc_base,
  input  logic [SZW-1:0]  desc_size,
  input  logic [IDXW-1:0] desc_idx,
  input  logic            desc_gen,
  input  logic            desc_flip,
  output logic            busy,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  output logic            upd_valid,
  output logic            upd_ok,
  output logic [IDXW-1:0] upd_idx,
  output logic            upd_gen,
  output logic            upd_flip,
  output logic            cfg_err
);
  localparam int unsigned SLOT_SH = $clog2(DW / 8);

  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic [DW-1:0]   cap_data;
  logic [AW-1:0]   cap_base;
  logic [SZW-1:0]  cap_size;
  logic [IDXW-1:0] cap_idx, idx_masked, step_idx;
  logic            cap_gen, cap_flip, step_gen, step_flip;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  evq_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW), .SZW(SZW), .MAX_SIZE(MAX_SIZE)) u_ctrl (
    .clk(clk), .rst_n(rst_sn),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .desc_base(desc_base), .desc_size(desc_size), .desc_idx(desc_idx),
    .desc_gen(desc_gen), .desc_flip(desc_flip),
    .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
    .cap_data(cap_data), .cap_base(cap_base), .cap_size(cap_size),
    .cap_idx(cap_idx), .cap_gen(cap_gen), .cap_flip(cap_flip),
    .step_idx(step_idx), .step_gen(step_gen), .step_flip(step_flip),
    .upd_valid(upd_valid), .upd_ok(upd_ok), .upd_idx(upd_idx),
    .upd_gen(upd_gen), .upd_flip(upd_flip), .cfg_err(cfg_err)
  );

  evq_index_step #(.IDXW(IDXW), .SZW(SZW)) u_step (
    .size(cap_size), .idx(cap_idx), .gen(cap_gen), .flip(cap_flip),
    .idx_masked(idx_masked), .idx_next(step_idx),
    .gen_next(step_gen), .flip_next(step_flip)
  );

  evq_entry_fmt #(.DW(DW)) u_fmt (
    .gen(cap_gen), .data(cap_data), .bus_word(mem_wdata)
  );

  assign mem_addr = cap_base + (AW'(idx_masked) << SLOT_SH);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  p_upd_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    upd_valid |-> $past(mem_req && mem_ack));
  p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (upd_valid && upd_ok && upd_idx == '0) |-> (upd_flip == upd_gen));
  p_no_req_on_update_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    upd_valid |-> !mem_req);
endmodule

// File: tb/tb_evq_writer.sv
module tb_evq_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, busy, mem_req, mem_ack, mem_err;
  logic [31:0] req_data, desc_base, mem_addr, mem_wdata;
  logic [2:0]  desc_size;
  logic [14:0] desc_idx, upd_idx;
  logic        desc_gen, desc_flip, upd_valid, upd_ok, upd_gen, upd_flip, cfg_err;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evq_writer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .desc_base(desc_base), .desc_size(desc_size),
    .desc_idx(desc_idx), .desc_gen(desc_gen), .desc_flip(desc_flip),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .upd_valid(upd_valid), .upd_ok(upd_ok),
    .upd_idx(upd_idx), .upd_gen(upd_gen), .upd_flip(upd_flip), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic g, input logic [31:0] d);
    logic [31:0] e = {g, d[30:0]};
    return {e[7:0], e[15:8], e[23:16], e[31:24]};
  endfunction

  task automatic enq(input logic [31:0] d, input logic [31:0] base, input logic [2:0] sz,
                     input logic [14:0] idx, input logic g, input logic f,
                     input int dly, input bit err);
    logic [14:0] mask, im, nidx;
    logic [31:0] eaddr;
    logic eg, ef;
    @(negedge clk);
    req_valid = 1'b1; req_data = d; desc_base = base; desc_size = sz;
    desc_idx = idx; desc_gen = g; desc_flip = f;
    #0 chk(req_ready == 1'b1, "R8 ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (sz > 3'd5) begin
      chk(cfg_err == 1'b1, "R7 cfg_err pulse", cfg_err, 1);
      chk(mem_req == 1'b0 && busy == 1'b0, "R7 no write", {busy, mem_req}, 0);
      @(negedge clk);
      chk(cfg_err == 1'b0 && upd_valid == 1'b0 && mem_req == 1'b0, "R7 one cycle, no update",
          {cfg_err, upd_valid, mem_req}, 0);
      return;
    end
    mask  = 15'((32'd1 << (32'(sz) + 32'd10)) - 32'd1);
    im    = idx & mask;
    nidx  = (im + 15'd1) & mask;
    eaddr = base + {15'd0, im, 2'b00};
    eg    = (nidx == 15'd0) ? ~g : g;
    ef    = (nidx == 15'd0) ? ~g : f;
    chk(busy && mem_req, "R8 busy and req after accept", {busy, mem_req}, 3);
    chk(mem_addr == eaddr, "R3 address", mem_addr, eaddr);
    chk(mem_wdata == exp_word(g, d), "R1 R2 entry bytes", mem_wdata, exp_word(g, d));
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == eaddr && mem_wdata == exp_word(g, d) && !upd_valid,
          "R8 hold while waiting", mem_addr, eaddr);
    end
    mem_ack = 1'b1; mem_err = err;
    @(negedge clk);
    mem_ack = 1'b0; mem_err = 1'b0;
    chk(upd_valid == 1'b1 && busy == 1'b0 && mem_req == 1'b0, "R4 update presented",
        {upd_valid, busy, mem_req}, 4);
    if (err) begin
      chk(upd_ok == 1'b0, "R6 not ok", upd_ok, 0);
      chk(upd_idx == idx && upd_gen == g && upd_flip == f, "R6 unchanged",
          {upd_idx, upd_gen, upd_flip}, {idx, g, f});
    end else begin
      chk(upd_ok == 1'b1, "R4 ok", upd_ok, 1);
      chk(upd_idx == nidx, "R4 index advance", upd_idx, nidx);
      chk(upd_gen == eg && upd_flip == ef, "R5 generation and flag",
          {upd_gen, upd_flip}, {eg, ef});
    end
    @(negedge clk);
    chk(upd_valid == 1'b0, "R4 single-cycle update", upd_valid, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 1'b0; mem_ack = 1'b0; mem_err = 1'b0;
    req_data = '0; desc_base = '0; desc_size = '0; desc_idx = '0;
    desc_gen = 1'b0; desc_flip = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !busy && !upd_valid && !cfg_err && req_ready, "R9 reset state",
        {mem_req, busy, upd_valid, cfg_err, req_ready}, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !busy && req_ready, "R9 after release", {mem_req, busy, req_ready}, 1);
    // directed corners
    enq(32'hFFFF_FFFF, 32'h1000_0000, 3'd0, 15'd1023, 1'b0, 1'b1, 0, 1'b0); // R5 wrap small
    enq(32'h8123_4567, 32'h2000_0000, 3'd5, 15'd32767, 1'b1, 1'b1, 2, 1'b0); // R5 wrap large
    enq(32'h0000_0001, 32'h0000_1000, 3'd2, 15'd5, 1'b1, 1'b0, 1, 1'b0);    // R4 plain
    enq(32'h7654_3210, 32'hFFFF_FFF0, 3'd0, 15'd1030, 1'b0, 1'b0, 0, 1'b0); // R3 masked idx, addr wrap
    enq(32'hDEAD_BEEF, 32'h3000_0000, 3'd1, 15'd2047, 1'b0, 1'b0, 3, 1'b1); // R6 error at wrap
    enq(32'h1111_2222, 32'h4000_0000, 3'd6, 15'd0, 1'b0, 1'b0, 0, 1'b0);    // R7 code 6
    enq(32'h3333_4444, 32'h4000_0000, 3'd7, 15'd9, 1'b1, 1'b0, 0, 1'b0);    // R7 code 7
    for (int n = 0; n < 300; n++) begin
      logic [2:0]  sz = 3'($urandom_range(0, 7));
      logic [14:0] ix = 15'($urandom);
      if ($urandom_range(0, 3) == 0) ix = 15'((32'd1 << (32'(sz) + 32'd10)) - 32'd1);
      enq($urandom, $urandom, sz, ix, 1'($urandom), 1'($urandom),
          int'($urandom_range(0, 3)), $urandom_range(0, 4) == 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule